// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a simple valid/ready request port and an asynchronous 32K x 8 static RAM. Each accepted request becomes exactly one memory access. A read drives chip enable and output enable low, then captures the returned byte and reports it with a one-cycle valid pulse. A write drives chip enable, write enable and output enable low. It keeps its own bus driver off until the memory has released the bus, then presents the write data, and ends the write by raising write enable and chip enable together. The host holds a request steady until it sees ready high. The controller keeps ready low for the whole access.

The memory timing figures are given as parameters in picoseconds, together with the clock period. At elaboration each figure becomes a whole number of cycles, rounded up and never less than one. The read wait covers the access time. The write has two phases. The release phase covers the time the memory takes to stop driving after write enable falls. The drive phase lasts long enough for the data setup time, and long enough for the remaining write pulse width and address-to-write-end time. The bidirectional data bus leaves the block as three separate signals: data out, output enable and data in. The pad cell that joins them sits outside the block.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and in every cycle in which the controller is idle, chip enable, write enable and output enable are high (inactive), the data driver is off, ready is high and read-valid is low.
- R2: During a read access, chip enable and output enable are low and write enable is high. The memory address equals the requested address and does not change, and the data driver stays off.
- R3: For a read, the byte on the data input is captured on the clock edge that ends a wait of N_RD cycles after acceptance. Read-valid is high for exactly the one following cycle, while chip enable and output enable are still low, and carries the captured byte.
- R4: During a write access, chip enable, write enable and output enable are all low for N_HZ + N_WD cycles and the address is held. For the first N_HZ of those cycles, the bus release wait, the controller does not drive the data bus.
- R5: The write byte is driven for the last N_WD cycles of the write. The driver turns off on the same clock edge that raises write enable, and the driver is never on while write enable or chip enable is high.
- R6: Ready falls on the edge that accepts a request. It stays low for N_RD + 1 cycles after a read and for N_HZ + N_WD cycles after a write, and then returns high with all strobes inactive.
- R7: A request presented while ready is low is neither accepted nor lost. It is accepted on the first edge at which ready is high, and it is carried out exactly once.
- R8: The controller never drives the data bus in a cycle in which the memory may still be driving it: not during a read, and not within N_HZ cycles after write enable falls.
- R9: Each cycle count is the ceiling of its time parameter divided by the clock period, with a minimum of 1. N_RD comes from the access time and N_HZ from the release time. N_WD is the largest of the setup count, the pulse-width count minus N_HZ, the address-to-end count minus N_HZ, and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | DATA_W | Captured read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | DATA_W | Byte sampled from the data bus |

## Verification
All outputs are registered. Counting from the accepting edge, a read's valid pulse appears N_RD edges later, and ready returns after N_RD + 1 edges. For a write, the data driver turns on after N_HZ edges, and write enable and ready return after N_HZ + N_WD edges. The bench samples every output on the falling clock edge. It indexes each observation by the number of falling edges since acceptance, so every check compares against the cycle the requirement names. The bench's memory model presents valid read data only in the last cycle before the capture edge, so a capture one edge early reads a marker value. The model also treats the bus as still driven by the memory for N_HZ cycles after write enable falls, so a driver that turns on early shows up as contention.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_WAIT = 3'd1,
      ST_RD_DONE = 3'd2,
      ST_WR_REL  = 3'd3,
      ST_WR_DRV  = 3'd4
   } asram_state_t;

   // ceiling of a time over the clock period, never below one cycle
   function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // count left after the release phase has already elapsed
   function automatic int rest_after(input int total, input int spent);
      return (total > spent) ? (total - spent) : 1;
   endfunction

   function automatic int cnt_bits(input int max_val);
      int b;
      b = $clog2(max_val + 1);
      if (b < 1) b = 1;
      return b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int N_RD  = 2,
   parameter int N_HZ  = 1,
   parameter int N_WD  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output logic             req_ready,
   output logic             rd_valid,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
   localparam logic [CNT_W-1:0] LD_HZ = CNT_W'(N_HZ - 1);
   localparam logic [CNT_W-1:0] LD_WD = CNT_W'(N_WD - 1);

   asram_state_t state_q, state_d;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept   = 1'b1;
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_REL;
                  tmr_val = LD_HZ;
               end else begin
                  state_d = ST_RD_WAIT;
                  tmr_val = LD_RD;
               end
            end
         end
         ST_RD_WAIT: begin
            if (tmr_expired) begin
               capture = 1'b1;
               state_d = ST_RD_DONE;
            end
         end
         ST_RD_DONE: state_d = ST_IDLE;
         ST_WR_REL: begin
            if (tmr_expired) begin
               state_d  = ST_WR_DRV;
               tmr_load = 1'b1;
               tmr_val  = LD_WD;
            end
         end
         ST_WR_DRV: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // strobes come straight from flops so the pads never see decode glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         req_ready <= 1'b1;
         rd_valid  <= 1'b0;
         ce_n      <= 1'b1;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         dq_oe     <= 1'b0;
      end else begin
         state_q   <= state_d;
         req_ready <= (state_d == ST_IDLE);
         rd_valid  <= (state_d == ST_RD_DONE);
         ce_n      <= (state_d == ST_IDLE);
         oe_n      <= (state_d == ST_IDLE);
         we_n      <= !((state_d == ST_WR_REL) || (state_d == ST_WR_DRV));
         dq_oe     <= (state_d == ST_WR_DRV);
      end
   end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (capture) begin
         rd_data <= mem_dq_in;
      end
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 10000,
   parameter int T_ACC_PS  = 20000,
   parameter int T_REL_PS  = 7000,
   parameter int T_SU_PS   = 10000,
   parameter int T_PW_PS   = 12000,
   parameter int T_AEND_PS = 12000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int N_RD  = ps_to_cyc(T_ACC_PS, CLK_PS);
   localparam int N_HZ  = ps_to_cyc(T_REL_PS, CLK_PS);
   localparam int N_SU  = ps_to_cyc(T_SU_PS, CLK_PS);
   localparam int N_PW  = ps_to_cyc(T_PW_PS, CLK_PS);
   localparam int N_AE  = ps_to_cyc(T_AEND_PS, CLK_PS);
   localparam int N_WD  = max_of(N_SU, max_of(rest_after(N_PW, N_HZ),
                                              rest_after(N_AE, N_HZ)));
   localparam int CNT_W = cnt_bits(max_of(N_RD, max_of(N_HZ, N_WD)));

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("asram_ctrl: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("asram_ctrl: DATA_W must be at least 1");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("asram_ctrl: CLK_PS must be positive");
      end
      if ((T_ACC_PS < 0) || (T_REL_PS < 0) || (T_SU_PS < 0) ||
          (T_PW_PS < 0) || (T_AEND_PS < 0)) begin : g_bad_time
         $error("asram_ctrl: timing parameters must not be negative");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             accept;
   logic             capture;

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   asram_fsm #(
      .CNT_W (CNT_W),
      .N_RD  (N_RD),
      .N_HZ  (N_HZ),
      .N_WD  (N_WD)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .accept      (accept),
      .capture     (capture),
      .req_ready   (req_ready),
      .rd_valid    (rd_valid),
      .ce_n        (mem_ce_n),
      .we_n        (mem_we_n),
      .oe_n        (mem_oe_n),
      .dq_oe       (mem_dq_oe)
   );

   asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid));

   assert_read_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe);

   assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

   assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_rd_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!mem_ce_n && !mem_oe_n));

   assert_no_drive_at_we_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> !mem_dq_oe);

   assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

   assert_drive_off_at_we_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($past(mem_dq_oe) && !mem_dq_oe));

   assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_addr  (mem_addr),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

   localparam int CLK_PERIOD = 10;
   // R9: 10000 ps clock; 36000 -> 4, 14000 -> 2, 16000 -> 2,
   // 44000 -> 5 (minus 2 = 3), 24000 -> 3 (minus 2 = 1): write drive = 3
   localparam int E_RD = 4;
   localparam int E_HZ = 2;
   localparam int E_WD = 3;
   localparam int NVEC = 9;

   // {write, addr[14:0], wdata[7:0], expected read[7:0]}
   localparam logic [31:0] VEC [NVEC] = '{
      {1'b1, 15'h7FFF, 8'hA5, 8'h00},
      {1'b1, 15'h0000, 8'h3C, 8'h00},
      {1'b0, 15'h7FFF, 8'h00, 8'hA5},
      {1'b0, 15'h0000, 8'h00, 8'h3C},
      {1'b1, 15'h2AAA, 8'h5A, 8'h00},
      {1'b0, 15'h2AAA, 8'h00, 8'h5A},
      {1'b1, 15'h7FFF, 8'h0F, 8'h00},
      {1'b0, 15'h7FFF, 8'h00, 8'h0F},
      {1'b0, 15'h1555, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int acc_cnt = 0;
   int contention = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   asram_ctrl #(
      .ADDR_W(15), .DATA_W(8), .CLK_PS(10000),
      .T_ACC_PS(36000), .T_REL_PS(14000), .T_SU_PS(16000),
      .T_PW_PS(44000), .T_AEND_PS(24000)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // ---------------- memory model ----------------
   logic [7:0] mem_m [1024];
   int  rd_age = 0;
   int  we_age = 0;
   bit  wr_pend = 1'b0;
   int  wr_drv = 0;
   logic [7:0] wr_byte = '0;
   logic [9:0] wr_idx = '0;
   logic rd_drive, mem_busy;

   initial for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;

   assign rd_drive  = !mem_ce_n && !mem_oe_n && mem_we_n;
   // memory keeps driving for E_HZ cycles after write enable falls
   assign mem_busy  = !mem_ce_n && !mem_oe_n && (mem_we_n || (we_age < E_HZ));
   assign mem_dq_in = !rd_drive ? 8'h00 :
                      (rd_age >= E_RD - 1) ? mem_m[mem_addr[9:0]] : 8'hEE;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst_n && req_valid && req_ready) acc_cnt <= acc_cnt + 1;
      rd_age <= rd_drive ? rd_age + 1 : 0;
   end

   always @(negedge clk) begin
      if (rst_n && mem_dq_oe && mem_busy) contention <= contention + 1;
      if (!mem_ce_n && !mem_we_n) begin
         we_age  <= we_age + 1;
         wr_pend <= 1'b1;
         if (mem_dq_oe) begin
            wr_drv  <= wr_drv + 1;
            wr_byte <= mem_dq_out;
            wr_idx  <= mem_addr[9:0];
         end
      end else begin
         we_age <= 0;
         if (wr_pend && wr_drv > 0) mem_m[wr_idx] <= wr_byte;
         wr_pend <= 1'b0;
         wr_drv  <= 0;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic run_access(input logic wr, input logic [14:0] a,
                             input logic [7:0] d, input logic [7:0] exp);
      int  k;
      bit  strobe_ok, drive_ok, pulse_ok;
      logic [7:0] got;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      k = 0; strobe_ok = 1; drive_ok = 1; pulse_ok = 1; got = 8'h00;
      while (!req_ready && k < 40) begin
         if (mem_ce_n !== 1'b0 || mem_oe_n !== 1'b0 ||
             mem_we_n !== (wr ? 1'b0 : 1'b1) || mem_addr !== a) strobe_ok = 0;
         if (wr) begin
            if (mem_dq_oe !== (k >= E_HZ)) drive_ok = 0;
            if (mem_dq_oe && mem_dq_out !== d) drive_ok = 0;
         end else begin
            if (mem_dq_oe !== 1'b0) drive_ok = 0;
            if (rd_valid !== (k == E_RD)) pulse_ok = 0;
            if (k == E_RD) got = rd_data;
         end
         k++;
         @(negedge clk);
      end
      chk(k == (wr ? E_HZ + E_WD : E_RD + 1), "R6 R9 busy length", k,
          wr ? E_HZ + E_WD : E_RD + 1);
      if (wr) begin
         chk(strobe_ok, "R4 write strobes/address", 0, 1);
         chk(drive_ok, "R5 drive window and byte", 0, 1);
      end else begin
         chk(strobe_ok, "R2 read strobes/address", 0, 1);
         chk(drive_ok, "R8 no drive during read", 0, 1);
         chk(pulse_ok, "R3 valid pulse timing", 0, 1);
         chk(got == exp, "R3 read byte", got, exp);
      end
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
          "R1 idle after access", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
   endtask

   initial begin
      wait (cycles > 50000);
      chk(1'b0, "watchdog expired", cycles, 50000);
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
          "R1 in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && req_ready, "R1 after reset",
          {mem_ce_n, mem_oe_n, req_ready}, 3'b111);

      for (int v = 0; v < NVEC; v++)
         run_access(VEC[v][31], VEC[v][30:16], VEC[v][15:8], VEC[v][7:0]);

      // R7: write request held while a read is busy
      begin
         int n;
         int acc0;
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
         while (!req_ready) @(negedge clk);
         @(negedge clk);
         req_write = 1'b1; req_addr = 15'h4321; req_wdata = 8'hC3;
         acc0 = acc_cnt;
         n = 0;
         while (!req_ready && n < 40) begin
            n++;
            @(negedge clk);
         end
         chk(n == E_RD + 1 && acc_cnt == acc0, "R7 held off while busy", n, E_RD + 1);
         @(negedge clk);
         req_valid = 1'b0;
         chk(acc_cnt == acc0 + 1 && !req_ready && !mem_we_n, "R7 accepted once",
             acc_cnt - acc0, 1);
         while (!req_ready) @(negedge clk);
         repeat (2) @(negedge clk);
         chk(acc_cnt == acc0 + 1, "R7 no second accept", acc_cnt - acc0, 1);
         run_access(1'b0, 15'h4321, 8'h00, 8'hC3);
      end

      // R1: reset in the middle of the bus release phase
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0077; req_wdata = 8'h99;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
          "R1 reset during write", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      run_access(1'b0, 15'h0077, 8'h00, 8'h00);

      chk(contention == 0, "R8 bus contention cycles", contention, 0);
      finish_run();
   end

endmodule